// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a register write into a software-generated interrupt (SGI) raised by one CPU towards a set of CPUs. For every pair of target CPU and SGI number it keeps a bitmap of the CPUs that raised the interrupt. The interrupt is pending for a target as long as that bitmap holds at least one bit.

A 32-bit register bus gives access to three things. The first is a trigger word that performs the dispatch. The other two are a set view and a clear view of the accessing CPU's source bitmaps. Every bus access carries the identity of the CPU that makes it. A separate input gives the number of online CPUs.

A CPU interface uses the consume port to retire one source of one SGI at a time. It reads the per-CPU, per-SGI pending outputs to see what is waiting.

Top module: `sgi_dispatcher`

## Requirements
- R1: A write to word 0 dispatches an SGI. Bits [3:0] hold the SGI number, bits [23:16] the target list (bit j means CPU j) and bits [25:24] the filter mode. In mode 0 the target list is used as written, except that bits for CPUs at or above `ncpus_i` are ignored.
- R2: Filter mode 1 targets every online CPU (index below `ncpus_i`) except the requester.
- R3: Filter mode 2 targets only the requester, whatever the target list holds.
- R4: Filter mode 3 is reserved. A trigger write in mode 3 changes no bitmap and no pending output.
- R5: For each selected target, the dispatch sets bit `cpu_id_i` of that target's source bitmap for the SGI. The pending output `pend_o[target*NUM_SGIS+sgi]` is high from the cycle after the write.
- R6: A read of word 0 returns zero.
- R7: Words 4+k form the set view and words 8+k the clear view, for k = 0..3. In either view, byte n of word k holds the source bitmap of SGI 4k+n, and bit j of that byte means source CPU j. A read returns the bitmaps of the CPU given on `cpu_id_i`, on `rdata_o` in the cycle after the request.
- R8: A write to set-view word k ORs each data byte into the accessing CPU's bitmap for the matching SGI.
- R9: A write to clear-view word k clears the written bits. An SGI whose bitmap reaches zero drops its pending output in the same cycle as the bitmap update.
- R10: A consume (`cons_valid_i`) clears bit `cons_src_i` of the bitmap of SGI `cons_sgi_i` at CPU `cons_cpu_i`. The SGI stays pending while any other source bit remains.
- R11: Reset clears every source bitmap and every pending output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Access is a write |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| cpu_id_i | input | CPU_W | CPU making the access (requester or viewer) |
| ncpus_i | input | CNT_W | Number of online CPUs |
| rdata_o | output | 32 | Read data, one cycle after a read request |
| cons_valid_i | input | 1 | Retire one source |
| cons_cpu_i | input | CPU_W | CPU whose SGI is retired |
| cons_sgi_i | input | SGI_W | SGI number retired |
| cons_src_i | input | CPU_W | Source CPU bit to clear |
| pend_o | output | NUM_CPUS*NUM_SGIS | Pending flags, bit c*NUM_SGIS+s |

## Verification
The assertions take `cpu_id_i`, `cons_cpu_i` and `cons_src_i` to be below NUM_CPUS and `ncpus_i` to be at most NUM_CPUS. The trigger checks also require that no consume lands in the same cycle as a trigger write. The bench drives only legal CPU indices and online counts of 1, 3 and 8. It keeps consumes and bus writes in separate cycles, so every expected bitmap follows from plain arithmetic on the requirement fields.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_mode_e;

  localparam int TRIG_WORD = 0;
  localparam int SET_BASE  = 4;
  localparam int CLR_BASE  = 8;
  localparam int SGI_PER_WORD = 4;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SGIS = 16,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W = $clog2(NUM_CPUS + 1),
  localparam int SGI_W = $clog2(NUM_SGIS)
) (
  input  logic [31:0]         wdata_i,
  input  logic [CPU_W-1:0]    req_cpu_i,
  input  logic [CNT_W-1:0]    ncpus_i,
  output flt_mode_e           mode_o,
  output logic [SGI_W-1:0]    sgi_o,
  output logic [NUM_CPUS-1:0] tgt_o
);
  logic [NUM_CPUS-1:0] online;
  logic [NUM_CPUS-1:0] self_oh;

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_online
    assign online[i] = (CNT_W'(i) < ncpus_i);
  end

  assign self_oh = NUM_CPUS'(1) << req_cpu_i;
  assign mode_o  = flt_mode_e'(wdata_i[25:24]);
  assign sgi_o   = wdata_i[SGI_W-1:0];

  always_comb begin
    unique case (mode_o)
      FLT_LIST:   tgt_o = wdata_i[16 +: NUM_CPUS] & online;
      FLT_OTHERS: tgt_o = online & ~self_oh;
      FLT_SELF:   tgt_o = self_oh;
      default:    tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
  parameter int NUM_CPUS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CPUS-1:0] set_i,
  input  logic [NUM_CPUS-1:0] clr_i,
  output logic [NUM_CPUS-1:0] src_o,
  output logic                pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_o <= '0;
    else         src_o <= (src_o | set_i) & ~clr_i;
  end

  assign pend_o = |src_o;

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~clr_i) != '0) |=> pend_o); // R5
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((src_o & $past(clr_i)) == '0)); // R9
  AST_DROP_ONLY_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> ($past(clr_i) != '0)); // R10
endmodule

// File: rtl/sgi_reg_view.sv
module sgi_reg_view
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SGIS = 16,
  parameter int ADDR_W   = 4,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NWORDS = NUM_SGIS / SGI_PER_WORD
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           rd_i,
  input  logic [ADDR_W-1:0]                              addr_i,
  input  logic [CPU_W-1:0]                               cpu_i,
  input  logic [NUM_CPUS-1:0][NUM_SGIS-1:0][NUM_CPUS-1:0] src_i,
  output logic [31:0]                                    rdata_o
);
  logic [31:0] word;

  always_comb begin
    word = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (addr_i == ADDR_W'(SET_BASE + k) || addr_i == ADDR_W'(CLR_BASE + k)) begin
        for (int n = 0; n < SGI_PER_WORD; n++)
          word[8*n +: NUM_CPUS] = src_i[cpu_i][SGI_PER_WORD*k + n];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end

  AST_TRIG_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(TRIG_WORD)) |=> (rdata_o == '0)); // R6
endmodule

// File: rtl/sgi_dispatcher.sv
module sgi_dispatcher
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SGIS = 16,
  parameter int ADDR_W   = 4,
  localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W  = $clog2(NUM_CPUS + 1),
  localparam int SGI_W  = $clog2(NUM_SGIS),
  localparam int NPEND  = NUM_CPUS * NUM_SGIS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CPU_W-1:0]  cpu_id_i,
  input  logic [CNT_W-1:0]  ncpus_i,
  output logic [31:0]       rdata_o,
  input  logic              cons_valid_i,
  input  logic [CPU_W-1:0]  cons_cpu_i,
  input  logic [SGI_W-1:0]  cons_sgi_i,
  input  logic [CPU_W-1:0]  cons_src_i,
  output logic [NPEND-1:0]  pend_o
);
  logic                  trig_fire;
  logic                  wr_en;
  flt_mode_e             mode;
  logic [SGI_W-1:0]      trig_sgi;
  logic [NUM_CPUS-1:0]   tgt;
  logic [NUM_CPUS-1:0]   self_oh;
  logic [NUM_CPUS-1:0]   cons_oh;
  logic [NUM_CPUS-1:0][NUM_SGIS-1:0][NUM_CPUS-1:0] src;

  assign wr_en     = req_i & we_i;
  assign trig_fire = wr_en & (addr_i == ADDR_W'(TRIG_WORD));
  assign self_oh   = NUM_CPUS'(1) << cpu_id_i;
  assign cons_oh   = NUM_CPUS'(1) << cons_src_i;

  sgi_target_decode #(.NUM_CPUS(NUM_CPUS), .NUM_SGIS(NUM_SGIS)) i_decode (
    .wdata_i  (wdata_i),
    .req_cpu_i(cpu_id_i),
    .ncpus_i  (ncpus_i),
    .mode_o   (mode),
    .sgi_o    (trig_sgi),
    .tgt_o    (tgt)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SGIS; s++) begin : g_sgi
      localparam int WORD = s / SGI_PER_WORD;
      localparam int BYTE = s % SGI_PER_WORD;
      logic [NUM_CPUS-1:0] set_b, clr_b;
      logic own, set_hit, clr_hit, trig_hit, cons_hit;

      assign own      = (cpu_id_i == CPU_W'(c));
      assign trig_hit = trig_fire & tgt[c] & (trig_sgi == SGI_W'(s));
      assign set_hit  = wr_en & own & (addr_i == ADDR_W'(SET_BASE + WORD));
      assign clr_hit  = wr_en & own & (addr_i == ADDR_W'(CLR_BASE + WORD));
      assign cons_hit = cons_valid_i & (cons_cpu_i == CPU_W'(c)) & (cons_sgi_i == SGI_W'(s));

      assign set_b = (trig_hit ? self_oh : '0)
                   | (set_hit ? wdata_i[8*BYTE +: NUM_CPUS] : '0);
      assign clr_b = (clr_hit ? wdata_i[8*BYTE +: NUM_CPUS] : '0)
                   | (cons_hit ? cons_oh : '0);

      sgi_src_cell #(.NUM_CPUS(NUM_CPUS)) i_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_b),
        .clr_i (clr_b),
        .src_o (src[c][s]),
        .pend_o(pend_o[c*NUM_SGIS + s])
      );
    end
  end

  sgi_reg_view #(.NUM_CPUS(NUM_CPUS), .NUM_SGIS(NUM_SGIS), .ADDR_W(ADDR_W)) i_view (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (req_i & ~we_i),
    .addr_i (addr_i),
    .cpu_i  (cpu_id_i),
    .src_i  (src),
    .rdata_o(rdata_o)
  );

  int self_idx;
  assign self_idx = int'(cpu_id_i) * NUM_SGIS + int'(trig_sgi);

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_fire && mode == FLT_RSVD && !cons_valid_i) |=> $stable(pend_o)); // R4
  AST_SELF_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_fire && mode == FLT_SELF && !cons_valid_i) |=> pend_o[$past(self_idx)]); // R3
  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_fire && mode == FLT_OTHERS && !pend_o[self_idx]) |=> !pend_o[$past(self_idx)]); // R2
endmodule

// File: tb/test_sgi_dispatcher.sv
module test_sgi_dispatcher;
  localparam int NC = 8;
  localparam int NS = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  cpu_id = '0;
  logic [3:0]  ncpus = 4'd8;
  logic [31:0] rdata;
  logic        cons_v = 0;
  logic [2:0]  cons_cpu = '0, cons_src = '0;
  logic [3:0]  cons_sgi = '0;
  logic [NC*NS-1:0] pend;

  logic [7:0] mdl [NC][NS];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sgi_dispatcher i_sgi_dispatcher (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .cpu_id_i(cpu_id), .ncpus_i(ncpus), .rdata_o(rdata),
    .cons_valid_i(cons_v), .cons_cpu_i(cons_cpu), .cons_sgi_i(cons_sgi),
    .cons_src_i(cons_src), .pend_o(pend)
  );

  task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int cpu, int a, logic [31:0] d);
    cpu_id = 3'(cpu); addr = 4'(a); wdata = d; req = 1; we = 1;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(int cpu, int a, output logic [31:0] d);
    cpu_id = 3'(cpu); addr = 4'(a); req = 1; we = 0;
    @(posedge clk); @(negedge clk);
    d = rdata; req = 0;
  endtask

  task automatic consume(int c, int s, int src);
    cons_cpu = 3'(c); cons_sgi = 4'(s); cons_src = 3'(src); cons_v = 1;
    @(posedge clk); @(negedge clk);
    cons_v = 0;
    mdl[c][s][src] = 1'b0;
  endtask

  function automatic logic [127:0] exp_pend();
    logic [127:0] p = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) p[c*NS+s] = |mdl[c][s];
    return p;
  endfunction

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 4; k++) begin
        rd(c, ((k + c) % 2 == 0) ? 4 + k : 8 + k, d);
        cmp(tag, 128'(d), 128'({mdl[c][4*k+3], mdl[c][4*k+2], mdl[c][4*k+1], mdl[c][4*k]}));
      end
    cmp(tag, 128'(pend), exp_pend());
  endtask

  task automatic trigger(int r, int n, int mode, int sgi, logic [7:0] lst);
    logic [7:0] online, tg;
    online = 8'((1 << n) - 1);
    case (mode)
      0: tg = lst & online;
      1: tg = online & ~(8'd1 << r);
      2: tg = 8'd1 << r;
      default: tg = 8'd0;
    endcase
    ncpus = 4'(n);
    wr(r, 0, {6'd0, 2'(mode), lst, 12'd0, 4'(sgi)});
    for (int c = 0; c < NC; c++) if (tg[c]) mdl[c][sgi][r] = 1'b1;
  endtask

  task automatic clear_mdl();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) mdl[c][s] = 8'd0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    string tag;
    int ns_list[3] = '{1, 3, 8};
    clear_mdl();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R11 reset");

    // sweep modes, requesters and online counts
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < NC; r++)
        for (int i = 0; i < 3; i++) begin
          tag = (m == 0) ? "R1 list" : (m == 1) ? "R2 others" : (m == 2) ? "R3 self" : "R4 reserved";
          trigger(r, ns_list[i], m, (m * 5 + r + i) % NS, 8'(8'hA5 ^ (r * 37 + i)));
          cmp({tag, " R5 pend"}, 128'(pend), exp_pend());
        end
    check_all("R5 R7 views");

    rd(2, 0, d);
    cmp("R6 trigger read", 128'(d), 128'd0);

    // set view OR
    wr(3, 5, 32'h0102_8040);
    mdl[3][4] |= 8'h40; mdl[3][5] |= 8'h80; mdl[3][6] |= 8'h02; mdl[3][7] |= 8'h01;
    cmp("R8 set pend", 128'(pend), exp_pend());
    wr(3, 5, 32'h1000_0001);
    mdl[3][4] |= 8'h01; mdl[3][7] |= 8'h10;
    check_all("R8 set OR");

    // clear view partial then full
    wr(0, 8, 32'h00FF_0F01);
    mdl[0][0] &= ~8'h01; mdl[0][1] &= ~8'h0F; mdl[0][2] = 8'h00;
    cmp("R9 clear partial", 128'(pend), exp_pend());
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 4; k++) begin
        wr(c, 8 + k, 32'hFFFF_FFFF);
        for (int n = 0; n < 4; n++) mdl[c][4*k+n] = 8'h00;
        cmp("R9 clear drops pend", 128'(pend), exp_pend());
      end
    check_all("R9 all clear");

    // consume one source at a time
    wr(2, 5, 32'h0000_0600);
    mdl[2][5] = 8'h06;
    consume(2, 5, 1);
    cmp("R10 still pending", 128'(pend[2*NS+5]), 128'd1);
    rd(2, 9, d);
    cmp("R10 bitmap", 128'(d), 128'h0000_0400);
    consume(2, 5, 2);
    cmp("R10 drop", 128'(pend[2*NS+5]), 128'd0);
    check_all("R10 after consume");

    // reserved mode with state present
    trigger(1, 8, 0, 9, 8'hFF);
    trigger(4, 8, 3, 9, 8'hFF);
    check_all("R4 reserved keeps state");

    // reset mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    clear_mdl();
    @(negedge clk);
    check_all("R11 mid reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule